// File: doc/BRIEF.md
# Wall-Bounce Steering Controller

This block is a Moore state machine that picks a steering command for a floor-cleaning robot from one wall-contact sensor bit. With no contact it steers straight. On a contact it turns, always in the direction opposite to the turn it made most recently. Because the command alone cannot show which way the robot last turned while it is driving straight, the straight command is held in two separate states. One marks a last turn to the left and the other a last turn to the right.

The sensor is sampled on every rising clock edge. A cycle with the sensor set produces one turn state, and the next cycle without it returns to straight. The command comes straight from the state register, so it changes only after a clock edge and never within a cycle. Reset is asserted asynchronously and active low. Its release is synchronised inside the block, so sensor samples taken during the release window are ignored.

Top module: `wall_bounce_steer`

## Requirements
- R1: While `rst_n` is low, `steer` is 2'b00, and this takes effect at once without waiting for a clock edge. After reset the remembered direction is "last turned left", so the first wall hit gives right (2'b10).
- R2: The `steer` encoding is 2'b00 for straight, 2'b01 for left and 2'b10 for right. The value 2'b11 never appears.
- R3: A rising edge with `wall_hit` low makes `steer` 2'b00 from any state.
- R4: In straight with last turn left, a rising edge with `wall_hit` high makes `steer` 2'b10 (right).
- R5: In straight with last turn right, a rising edge with `wall_hit` high makes `steer` 2'b01 (left).
- R6: While turning left, a rising edge with `wall_hit` high makes `steer` 2'b10 (right). Consecutive hits therefore alternate.
- R7: While turning right, a rising edge with `wall_hit` high makes `steer` 2'b01 (left).
- R8: The remembered last direction is kept through any number of cycles with `wall_hit` low.
- R9: With RST_SYNC_STAGES = 2, `wall_hit` is ignored on the first two rising edges after `rst_n` rises. On those edges `steer` stays 2'b00 and the remembered direction stays left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wall_hit | input | 1 | 1 = wall contact detected this cycle, 0 = none |
| steer | output | 2 | Steering command: 00 straight, 01 left, 10 right |

## Verification
A fixed sequence of sensor values walks all eight state and input pairs. The sequence includes:
- isolated hits separated by single idle cycles and by longer idle runs, which tell apart the two straight states that share an output;
- runs of back-to-back hits, which separate the turn-to-turn transitions from the straight-to-turn ones.

Directed cases assert reset mid-cycle from a turn state to show that the output clears asynchronously. They hold the sensor high across reset release to show that the release window ignores it. A long idle run checks that the remembered direction survives and controls the next turn.

// File: rtl/wall_bounce_pkg.sv
package wall_bounce_pkg;

  localparam int unsigned STEER_W = 2;

  // Internal heading state: straight states remember the last turn.
  typedef enum logic [1:0] {
    HD_FWD_AFTER_L = 2'b00,
    HD_FWD_AFTER_R = 2'b01,
    HD_TURN_L      = 2'b10,
    HD_TURN_R      = 2'b11
  } heading_e;

  localparam logic [STEER_W-1:0] CMD_STRAIGHT = 2'b00;
  localparam logic [STEER_W-1:0] CMD_LEFT     = 2'b01;
  localparam logic [STEER_W-1:0] CMD_RIGHT    = 2'b10;

  localparam heading_e HD_RESET = HD_FWD_AFTER_L;

endpackage

// File: rtl/wall_bounce_rst_sync.sv
module wall_bounce_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wall_bounce_next.sv
module wall_bounce_next
  import wall_bounce_pkg::*;
(
  input  heading_e cur_state,
  input  logic     hit,
  output heading_e nxt_state
);

  always_comb begin
    nxt_state = cur_state;
    if (!hit) begin
      // Turning ends; straight states keep their memory.
      case (cur_state)
        HD_TURN_L:      nxt_state = HD_FWD_AFTER_L;
        HD_TURN_R:      nxt_state = HD_FWD_AFTER_R;
        HD_FWD_AFTER_L: nxt_state = HD_FWD_AFTER_L;
        HD_FWD_AFTER_R: nxt_state = HD_FWD_AFTER_R;
        default:        nxt_state = HD_RESET;
      endcase
    end else begin
      // Turn opposite to the most recent non-straight direction.
      case (cur_state)
        HD_FWD_AFTER_L, HD_TURN_L: nxt_state = HD_TURN_R;
        HD_FWD_AFTER_R, HD_TURN_R: nxt_state = HD_TURN_L;
        default:                   nxt_state = HD_RESET;
      endcase
    end
  end

endmodule

// File: rtl/wall_bounce_state_reg.sv
module wall_bounce_state_reg
  import wall_bounce_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     upd_en,
  input  logic     hit,
  input  heading_e nxt_state,
  output heading_e state_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HD_RESET;
    end else if (upd_en) begin
      state_q <= nxt_state;
    end
  end

  // R3
  idle_goes_straight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (state_q == HD_FWD_AFTER_L || state_q == HD_FWD_AFTER_R));

  // R4
  fwd_l_hit_turns_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HD_FWD_AFTER_L && hit) |=> state_q == HD_TURN_R);

  // R5
  fwd_r_hit_turns_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HD_FWD_AFTER_R && hit) |=> state_q == HD_TURN_L);

  // R6
  turn_l_hit_turns_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HD_TURN_L && hit) |=> state_q == HD_TURN_R);

  // R7
  turn_r_hit_turns_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HD_TURN_R && hit) |=> state_q == HD_TURN_L);

  // R8
  memory_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HD_FWD_AFTER_R && !hit) |=> state_q == HD_FWD_AFTER_R);

endmodule

// File: rtl/wall_bounce_decode.sv
module wall_bounce_decode
  import wall_bounce_pkg::*;
(
  input  heading_e           state,
  output logic [STEER_W-1:0] cmd
);

  always_comb begin
    case (state)
      HD_TURN_L: cmd = CMD_LEFT;
      HD_TURN_R: cmd = CMD_RIGHT;
      default:   cmd = CMD_STRAIGHT;
    endcase
  end

endmodule

// File: rtl/wall_bounce_steer.sv
module wall_bounce_steer
  import wall_bounce_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wall_hit,
  output logic [STEER_W-1:0] steer
);

  logic     rst_int_n;
  logic     step_en;
  heading_e state_q;
  heading_e state_d;

  assign step_en = 1'b1;

  wall_bounce_rst_sync #(.STAGES(RST_SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  wall_bounce_next next_i (
    .cur_state (state_q),
    .hit       (wall_hit),
    .nxt_state (state_d)
  );

  wall_bounce_state_reg reg_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .upd_en    (step_en),
    .hit       (wall_hit),
    .nxt_state (state_d),
    .state_q   (state_q)
  );

  wall_bounce_decode dec_i (
    .state (state_q),
    .cmd   (steer)
  );

  // R2
  steer_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    steer != 2'b11);

  // R1
  reset_straight_chk: assert property (@(posedge clk)
    !rst_n |-> steer == CMD_STRAIGHT);

endmodule

// File: tb/wall_bounce_steer_tb.sv
`timescale 1ns/1ps
module wall_bounce_steer_tb_top;

  logic       clk;
  logic       rst_n;
  logic       wall_hit;
  logic [1:0] steer;

  int n_checks;
  int n_fails;
  bit done;

  localparam logic [1:0] S_ST = 2'b00;
  localparam logic [1:0] S_L  = 2'b01;
  localparam logic [1:0] S_R  = 2'b10;

  // Each entry: {wall_hit, expected steer after the edge}; starts from reset.
  localparam int NV = 16;
  localparam logic [2:0] VEC [NV] = '{
    {1'b0, 2'b00}, {1'b1, 2'b10}, {1'b0, 2'b00}, {1'b0, 2'b00},
    {1'b1, 2'b01}, {1'b0, 2'b00}, {1'b1, 2'b10}, {1'b1, 2'b01},
    {1'b1, 2'b10}, {1'b0, 2'b00}, {1'b1, 2'b01}, {1'b1, 2'b10},
    {1'b0, 2'b00}, {1'b1, 2'b01}, {1'b0, 2'b00}, {1'b0, 2'b00}
  };

  wall_bounce_steer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wall_hit (wall_hit),
    .steer    (steer)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [1:0] exp, input string tag);
    n_checks++;
    if (steer !== exp) begin
      n_fails++;
      $display("FAIL %s: steer=%b expected=%b at %0t", tag, steer, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [1:0] exp, input string tag);
    @(negedge clk);
    wall_hit = w;
    @(posedge clk);
    #1;
    check(exp, tag);
  endtask

  function automatic string tag_of(input logic w, input logic [1:0] prev, input logic last_left);
    if (!w) return "R3";
    if (prev == S_L) return "R6";
    if (prev == S_R) return "R7";
    return last_left ? "R4" : "R5";
  endfunction

  initial begin
    logic [1:0] prev;
    logic       last_left;
    n_checks = 0;
    n_fails  = 0;
    done     = 0;
    rst_n    = 1'b0;
    wall_hit = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(S_ST, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(S_ST, "R1 after release");

    // Vector walk; the tag follows the source state.
    prev = S_ST;
    last_left = 1'b1;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][2], VEC[i][1:0], tag_of(VEC[i][2], prev, last_left));
      if (VEC[i][1:0] == S_L) last_left = 1'b1;
      if (VEC[i][1:0] == S_R) last_left = 1'b0;
      prev = VEC[i][1:0];
    end

    // R8: long idle keeps "last right", next hit gives left.
    step(1'b1, S_R, "R4 prep");
    for (int k = 0; k < 20; k++) step(1'b0, S_ST, "R8 idle");
    step(1'b1, S_L, "R8 memory after idle");

    // R1: asynchronous reset mid-cycle from a turn state.
    step(1'b1, S_R, "R6 prep");
    #2;
    rst_n = 1'b0;
    #1;
    check(S_ST, "R1 async clear");
    @(negedge clk);
    wall_hit = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(S_ST, "R1 hit held in reset");

    // R9: hits on the release window edges are ignored.
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(S_ST, "R9 edge 1");
    @(posedge clk);
    #1;
    check(S_ST, "R9 edge 2");
    step(1'b0, S_ST, "R9 first active edge");
    step(1'b1, S_R, "R1 first hit turns right");
    step(1'b1, S_L, "R7 back to back");
    step(1'b0, S_ST, "R2 straight code");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

endmodule